// File: doc/BRIEF.md
# Companion I/O Register File with GPIO Bank

This block is the register file of a small companion I/O controller on a handheld board. A host reaches it over a simple synchronous bus: a 12-bit byte offset inside a 4 KB window, a write strobe with a 32-bit data word, and a read strobe whose data comes back one cycle later. It holds a set of 16-bit control registers: operating mode, card detect, card control, power control, three interrupt-related registers and a scratch GPIO read register. It also holds a fixed status word that reports the device as ready.

A 16-line GPIO bank sits behind two of those registers. A direction register marks which lines the block drives. A level register holds the line values. The published output vector is the level masked by the direction, and it is recomputed only when the host writes one of those two registers. Each line whose published value flips at that moment gives a one-cycle change strobe. The new value of the line is the matching bit of the output vector. Edges on the 16 input lines set or clear the matching level bit. The level register can then be read back, but the output vector does not move until the next direction or level write.

Accesses to offsets with no register behind them return zero and raise a one-cycle bad-address flag.

Top module: `cio_regfile`

## Requirements
- R1: Word-aligned offsets map to these registers: 0x00 mode, 0x04 card detect, 0x08 status, 0x0C power, 0x10 card control, 0x14 interrupt raw, 0x18 interrupt mask, 0x1C interrupt status, 0x20 GPIO direction, 0x24 GPIO level, 0x28 GPIO read. Each reads back what was written to it, except where another requirement says otherwise.
- R2: Only bits 15:0 of the 32-bit write word are stored. Bits 31:16 are dropped.
- R3: A write to the power register stores the value. If bit 7 of the value is 1, bits 15 and 6 are also stored as 1 (the value is ORed with 0x8040).
- R4: After reset the status register reads 0x0002. Every other register reads 0, and gpio_out, gpio_chg and bad_addr are 0.
- R5: A write to the level register stores the value ANDed with the current direction register.
- R6: After a direction or level write, gpio_chg pulses for exactly one cycle, only on the lines whose output bit differs from the previous output. The new value of each line is on gpio_out.
- R7: gpio_out equals level AND direction as computed at the last direction or level write. A direction write does not alter the stored level, and input-line edges do not move gpio_out.
- R8: A rising edge on a gpio_in line sets the matching level bit. A falling edge clears it. This applies whatever the direction.
- R9: The status register is read-only. A write to 0x08 changes nothing and is not flagged as bad.
- R10: A read from an unmapped offset returns 0 and pulses bad_addr for one cycle. Unmapped offsets are any offset above 0x28 or any offset that is not a multiple of 4.
- R11: A write to an unmapped offset changes no register and pulses bad_addr for one cycle.
- R12: When a level write and an input edge land in the same cycle, the write decides the level value and the input edge is discarded.
- R13: Read data appears on bus_rdata in the cycle after the read strobe is sampled, and holds while no read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset within the 4 KB window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; only the low 16 bits are kept |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| bad_addr | output | 1 | One-cycle pulse after an access to an unmapped offset |
| gpio_in | input | 16 | Input lines that update the level register on edges |
| gpio_out | output | 16 | Published output vector: level AND direction |
| gpio_chg | output | 16 | One-cycle per-line change strobes |

## Verification
The GPIO bank is driven with a sequence that separates its three sources of change. Direction writes that expose, hide and re-expose already stored level bits show that strobes follow the masked output and not the raw level. A level write with bits outside the direction shows the masking of stored data. Input edges on driven and undriven lines show that the level changes while gpio_out stays put until the next direction write.

The power register is written with bit 7 set, with bit 7 clear, and with bit 7 set together with other bits, so that the forced bits are told apart from the written ones. Unaligned offsets, offsets past the last register and far offsets are all probed, both for the zero read and for the absence of side effects. A level write that collides with an input edge on the same bit settles the priority between the two.

// File: rtl/cio_pkg.sv
package cio_pkg;

  localparam int unsigned REG_W   = 16;
  localparam int unsigned LAST_IX = 10;

  // Register select, numbered by word index within the window
  typedef enum logic [3:0] {
    SEL_MODE = 4'd0,
    SEL_CDET = 4'd1,
    SEL_STAT = 4'd2,
    SEL_PWR  = 4'd3,
    SEL_CCTL = 4'd4,
    SEL_IRAW = 4'd5,
    SEL_IMSK = 4'd6,
    SEL_ISTA = 4'd7,
    SEL_GDIR = 4'd8,
    SEL_GLVL = 4'd9,
    SEL_GRD  = 4'd10,
    SEL_NONE = 4'd15
  } sel_e;

  localparam logic [REG_W-1:0] STAT_READY = 16'h0002;
  localparam logic [REG_W-1:0] PWR_FORCE  = 16'h8040;
  localparam int unsigned      PWR_TRIG   = 7;

endpackage

// File: rtl/cio_addr_dec.sv
module cio_addr_dec
  import cio_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic [AW-1:0] addr,
  output sel_e          sel,
  output logic          hit
);

  localparam int unsigned IXW = AW - 2;

  logic [IXW-1:0] word_ix;

  always_comb begin
    word_ix = addr[AW-1:2];
    hit     = (addr[1:0] == 2'b00) && (word_ix <= IXW'(LAST_IX));
    sel     = hit ? sel_e'(word_ix[3:0]) : SEL_NONE;
  end

endmodule

// File: rtl/cio_ctrl_regs.sv
module cio_ctrl_regs
  import cio_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  sel_e          sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] cdet_q,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] pwr_q,
  output logic [DW-1:0] cctl_q,
  output logic [DW-1:0] iraw_q,
  output logic [DW-1:0] imsk_q,
  output logic [DW-1:0] ista_q,
  output logic [DW-1:0] grd_q
);

  logic [DW-1:0] pwr_next;

  always_comb begin
    pwr_next = wdata;
    if (wdata[PWR_TRIG]) pwr_next = wdata | DW'(PWR_FORCE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      cdet_q <= '0;
      stat_q <= DW'(STAT_READY);
      pwr_q  <= '0;
      cctl_q <= '0;
      iraw_q <= '0;
      imsk_q <= '0;
      ista_q <= '0;
      grd_q  <= '0;
    end else if (we) begin
      case (sel)
        SEL_MODE: mode_q <= wdata;
        SEL_CDET: cdet_q <= wdata;
        SEL_PWR:  pwr_q  <= pwr_next;
        SEL_CCTL: cctl_q <= wdata;
        SEL_IRAW: iraw_q <= wdata;
        SEL_IMSK: imsk_q <= wdata;
        SEL_ISTA: ista_q <= wdata;
        SEL_GRD:  grd_q  <= wdata;
        default: ;
      endcase
    end
  end

  AST_PWR_FORCED_BITS: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_PWR && wdata[PWR_TRIG]) |=> (pwr_q[15] && pwr_q[6])); // R3

  AST_STATUS_KEEPS_READY: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_STAT) |=> (stat_q == DW'(STAT_READY))); // R9

endmodule

// File: rtl/cio_gpio_bank.sv
module cio_gpio_bank #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_we,
  input  logic         lvl_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] lvl_q,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_chg
);

  logic [N-1:0] in_q;
  logic [N-1:0] in_edge;
  logic [N-1:0] lvl_next;
  logic [N-1:0] dir_next;
  logic [N-1:0] eff_next;
  logic         publish;

  always_comb begin
    in_edge  = pin_in ^ in_q;
    dir_next = dir_we ? wdata : dir_q;
    if (lvl_we) lvl_next = wdata & dir_q;
    else        lvl_next = (lvl_q & ~in_edge) | (pin_in & in_edge);
    eff_next = lvl_next & dir_next;
    publish  = dir_we | lvl_we;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q    <= '0;
      dir_q   <= '0;
      lvl_q   <= '0;
      pin_out <= '0;
      pin_chg <= '0;
    end else begin
      in_q  <= pin_in;
      dir_q <= dir_next;
      lvl_q <= lvl_next;
      if (publish) begin
        pin_chg <= pin_out ^ eff_next;
        pin_out <= eff_next;
      end else begin
        pin_chg <= '0;
      end
    end
  end

  AST_CHG_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (|pin_chg) |-> $past(dir_we || lvl_we)); // R6

  AST_CHG_MATCHES_FLIP: assert property (@(posedge clk) disable iff (rst)
    pin_chg == (pin_out ^ $past(pin_out))); // R6

  AST_OUT_INSIDE_DIR: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~dir_q) == '0); // R7

  AST_LVL_MASKED: assert property (@(posedge clk) disable iff (rst)
    lvl_we |=> ((lvl_q & ~dir_q) == '0)); // R5

endmodule

// File: rtl/cio_regfile.sv
module cio_regfile
  import cio_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned DW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  output logic              bad_addr,
  input  logic [DW-1:0]     gpio_in,
  output logic [DW-1:0]     gpio_out,
  output logic [DW-1:0]     gpio_chg
);

  localparam int unsigned NGPIO = DW;

  sel_e          sel;
  logic          hit;
  logic          reg_we;
  logic [DW-1:0] w16;
  logic          unused_hi;
  logic [DW-1:0] mode_q, cdet_q, stat_q, pwr_q, cctl_q;
  logic [DW-1:0] iraw_q, imsk_q, ista_q, grd_q;
  logic [NGPIO-1:0] dir_q, lvl_q;
  logic [DW-1:0] rd_mux;

  assign w16       = bus_wdata[DW-1:0];
  assign unused_hi = ^bus_wdata[BUS_W-1:DW];
  assign reg_we    = bus_wr & hit;

  cio_addr_dec #(.AW(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .hit  (hit)
  );

  cio_ctrl_regs #(.DW(DW)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we),
    .sel    (sel),
    .wdata  (w16),
    .mode_q (mode_q),
    .cdet_q (cdet_q),
    .stat_q (stat_q),
    .pwr_q  (pwr_q),
    .cctl_q (cctl_q),
    .iraw_q (iraw_q),
    .imsk_q (imsk_q),
    .ista_q (ista_q),
    .grd_q  (grd_q)
  );

  cio_gpio_bank #(.N(NGPIO)) u_gpio (
    .clk     (clk),
    .rst     (rst),
    .dir_we  (reg_we && sel == SEL_GDIR),
    .lvl_we  (reg_we && sel == SEL_GLVL),
    .wdata   (w16),
    .pin_in  (gpio_in),
    .dir_q   (dir_q),
    .lvl_q   (lvl_q),
    .pin_out (gpio_out),
    .pin_chg (gpio_chg)
  );

  always_comb begin
    case (sel)
      SEL_MODE: rd_mux = mode_q;
      SEL_CDET: rd_mux = cdet_q;
      SEL_STAT: rd_mux = stat_q;
      SEL_PWR:  rd_mux = pwr_q;
      SEL_CCTL: rd_mux = cctl_q;
      SEL_IRAW: rd_mux = iraw_q;
      SEL_IMSK: rd_mux = imsk_q;
      SEL_ISTA: rd_mux = ista_q;
      SEL_GDIR: rd_mux = dir_q;
      SEL_GLVL: rd_mux = lvl_q;
      SEL_GRD:  rd_mux = grd_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bad_addr  <= 1'b0;
    end else begin
      bad_addr <= (bus_rd | bus_wr) & ~hit;
      if (bus_rd) bus_rdata <= hit ? rd_mux : '0;
    end
  end

  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bad_addr && $past(bus_rd)) |-> (bus_rdata == '0)); // R10

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata)); // R13

  AST_BAD_IS_PULSE: assert property (@(posedge clk) disable iff (rst)
    bad_addr |-> $past(bus_rd || bus_wr)); // R11

endmodule

// File: tb/cio_regfile_bench.sv
module cio_regfile_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic        bad_addr;
  logic [15:0] gpio_in = '0;
  logic [15:0] gpio_out;
  logic [15:0] gpio_chg;

  always #5 clk = ~clk;

  cio_regfile u_cio_regfile (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .bad_addr  (bad_addr),
    .gpio_in   (gpio_in),
    .gpio_out  (gpio_out),
    .gpio_chg  (gpio_chg)
  );

  typedef struct {
    logic [15:0] data;
    logic        bad;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  logic pend = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor: compare each read result one cycle after the strobe edge
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R13 unexpected read result", bus_rdata, 16'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(bus_rdata === e.data, e.tag, bus_rdata, e.data);
        check(bad_addr === e.bad, {e.tag, " bad flag"}, {15'h0, bad_addr}, {15'h0, e.bad});
      end
    end
    pend <= bus_rd;
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [15:0] d, input logic bad, input string tag);
    exp_t e;
    e.data = d; e.bad = bad; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk); #2;
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #2;
    bus_rd = 1'b0;
  endtask

  task automatic gpio_chk(input logic [15:0] out_e, input logic [15:0] chg_e, input string tag);
    check(gpio_out === out_e, {tag, " gpio_out"}, gpio_out, out_e);
    check(gpio_chg === chg_e, {tag, " gpio_chg"}, gpio_chg, chg_e);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    // R4 reset state
    gpio_chk(16'h0, 16'h0, "R4 reset");
    check(bad_addr === 1'b0, "R4 reset bad_addr", {15'h0, bad_addr}, 16'h0);
    rd(12'h008, 16'h0002, 1'b0, "R4 status ready");
    rd(12'h000, 16'h0000, 1'b0, "R4 mode zero");
    rd(12'h00C, 16'h0000, 1'b0, "R4 power zero");
    rd(12'h020, 16'h0000, 1'b0, "R4 direction zero");

    // R1/R2 plain registers and truncation
    wr(12'h000, 32'h1234_ABCD);
    rd(12'h000, 16'hABCD, 1'b0, "R2 mode truncated");
    wr(12'h004, 32'h0000_0055);
    wr(12'h010, 32'h0000_00AA);
    wr(12'h014, 32'h0000_1111);
    wr(12'h018, 32'hFFFF_2222);
    wr(12'h01C, 32'h0000_3333);
    wr(12'h028, 32'h0000_4444);
    rd(12'h004, 16'h0055, 1'b0, "R1 card detect");
    rd(12'h010, 16'h00AA, 1'b0, "R1 card control");
    rd(12'h014, 16'h1111, 1'b0, "R1 irq raw");
    rd(12'h018, 16'h2222, 1'b0, "R1 irq mask");
    rd(12'h01C, 16'h3333, 1'b0, "R1 irq status");
    rd(12'h028, 16'h4444, 1'b0, "R1 gpio read");

    // R3 power side effect
    wr(12'h00C, 32'h0000_0080);
    rd(12'h00C, 16'h80C0, 1'b0, "R3 power bit7 forces");
    wr(12'h00C, 32'h0000_0001);
    rd(12'h00C, 16'h0001, 1'b0, "R3 power no force");
    wr(12'h00C, 32'h0001_0180);
    rd(12'h00C, 16'h81C0, 1'b0, "R3 power force with others");

    // R9 status read-only
    wr(12'h008, 32'h0000_FFFF);
    check(bad_addr === 1'b0, "R9 status write not bad", {15'h0, bad_addr}, 16'h0);
    rd(12'h008, 16'h0002, 1'b0, "R9 status unchanged");

    // R10 unmapped reads
    rd(12'h02C, 16'h0000, 1'b1, "R10 past last register");
    rd(12'h002, 16'h0000, 1'b1, "R10 unaligned");
    rd(12'hFFC, 16'h0000, 1'b1, "R10 far offset");

    // R11 unmapped writes
    wr(12'h030, 32'h0000_FFFF);
    check(bad_addr === 1'b1, "R11 write flag", {15'h0, bad_addr}, 16'h1);
    wr(12'h001, 32'h0000_FFFF);
    check(bad_addr === 1'b1, "R11 unaligned write flag", {15'h0, bad_addr}, 16'h1);
    @(posedge clk); #2;
    check(bad_addr === 1'b0, "R11 flag one cycle", {15'h0, bad_addr}, 16'h0);
    rd(12'h000, 16'hABCD, 1'b0, "R11 mode untouched");
    rd(12'h028, 16'h4444, 1'b0, "R11 gpio read untouched");
    rd(12'h020, 16'h0000, 1'b0, "R11 direction untouched");

    // GPIO bank
    wr(12'h020, 32'h0000_00FF);
    gpio_chk(16'h0000, 16'h0000, "R6 dir write no change");
    wr(12'h024, 32'h0000_F0F0);
    gpio_chk(16'h00F0, 16'h00F0, "R6 level write strobes");
    @(posedge clk); #2;
    gpio_chk(16'h00F0, 16'h0000, "R6 strobe one cycle");
    rd(12'h024, 16'h00F0, 1'b0, "R5 level masked");
    wr(12'h020, 32'h0000_0F0F);
    gpio_chk(16'h0000, 16'h00F0, "R7 dir hides outputs");
    rd(12'h024, 16'h00F0, 1'b0, "R7 level kept on dir write");
    wr(12'h020, 32'h0000_00FF);
    gpio_chk(16'h00F0, 16'h00F0, "R7 dir re-exposes");

    // R8 input edges
    gpio_in = 16'h0100;
    @(posedge clk); #2;
    gpio_chk(16'h00F0, 16'h0000, "R7 input leaves outputs");
    rd(12'h024, 16'h01F0, 1'b0, "R8 rising edge sets");
    gpio_in = 16'h0010;
    @(posedge clk); #2;
    gpio_in = 16'h0000;
    @(posedge clk); #2;
    rd(12'h024, 16'h00E0, 1'b0, "R8 falling edge clears");
    gpio_chk(16'h00F0, 16'h0000, "R7 outputs held after input");
    wr(12'h020, 32'h0000_00FF);
    gpio_chk(16'h00E0, 16'h0010, "R6 only flipped line");

    // R12 write beats input edge
    @(posedge clk); #2;
    gpio_in = 16'h0008;
    bus_addr = 12'h024; bus_wdata = 32'h0000_00A0; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0;
    gpio_chk(16'h00A0, 16'h0040, "R12 write result published");
    rd(12'h024, 16'h00A0, 1'b0, "R12 write wins over edge");
    gpio_in = 16'h0000;

    repeat (3) @(posedge clk);
    #2;
    check(exp_q.size() == 0, "R13 all reads returned", 16'(exp_q.size()), 16'h0);
    done = 1;
    summary();
    $finish;
  end

endmodule